// File: doc/BRIEF.md
# Bytecode Prefetch and Operand Formatter

This block sits between a 16-bit code memory and the sequencer of a bytecode interpreter. It keeps a small ring of code bytes topped up by issuing word-aligned 16-bit reads. On request it hands the sequencer the next operand in the format the sequencer picks. There are four formats: a byte with sign extension, a byte with zero extension, a little-endian 16-bit word, and a compact variable-length integer. The compact integer takes one byte for values below 128 and two bytes for values up to 32767. Bytes are taken from the ring at any alignment, so operands may straddle memory words.

When the interpreter jumps, the sequencer pulses a flush with a new byte address. The ring is emptied, any memory data returned in that same cycle is dropped, and fetching restarts at the word that holds the target byte. If the target address is odd, the low byte of that first word is thrown away.

Top module: `bcp_prefetch`

## Requirements
- R1: After reset the ring is empty, `op_valid` is low, `mem_req` is high and `mem_addr` is 0, so the first operand comes from byte address 0.
- R2: Format 0 returns the next byte sign-extended to 16 bits and consumes one byte.
- R3: Format 1 returns the next byte zero-extended (bits 15:8 zero) and consumes one byte.
- R4: Format 2 returns {byte[p+1], byte[p]} for the next byte address p, whatever p's alignment, and consumes two bytes.
- R5: Format 3 returns the first byte when its bit 7 is clear and consumes one byte. When bit 7 is set it returns {1'b0, first[6:0], second[7:0]} and consumes two bytes. Bit 15 of the result is always 0.
- R6: `op_valid` stays low until the ring holds enough bytes for the selected format: one for formats 0 and 1, two for format 2, and two for format 3 when the first byte has bit 7 set.
- R7: `mem_req` is raised only while at least two ring slots are free. `mem_addr` is always even. Address and request hold until `mem_ack` unless a flush intervenes. Each accepted beat advances the address by 2.
- R8: A flush empties the ring and forces `op_valid` low in its cycle. It drops any beat acknowledged in that cycle, and the next request goes to `flush_addr` with bit 0 cleared.
- R9: After a flush to an odd address, only the high byte of the first beat enters the ring, so the next operand starts exactly at `flush_addr`.
- R10: No byte is consumed in a cycle where `op_req` or `op_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | output | 1 | Read request to code memory |
| mem_addr | output | 16 | Even byte address of the requested word |
| mem_ack | input | 1 | Memory accepts the request; `mem_rdata` is valid in this cycle |
| mem_rdata | input | 16 | Read word; bits 7:0 hold the even-address byte |
| flush | input | 1 | Jump: discard buffered bytes and refetch |
| flush_addr | input | 16 | Byte address of the jump target |
| op_req | input | 1 | Sequencer requests an operand |
| op_fmt | input | 2 | 0 signed byte, 1 unsigned byte, 2 word, 3 compact integer |
| op_valid | output | 1 | Enough bytes are present for the selected format |
| op_data | output | 16 | Formatted operand |

## Verification
`op_valid` and `op_data` respond combinationally to `op_fmt` in the same cycle, so the bench sets the request just after a falling edge and reads the result half a cycle later. Bytes consumed at a rising edge and bytes from a beat accepted at that edge only show up from the next cycle. `mem_addr` takes the flush target from the cycle after the flush, and the bench reads it half a cycle after that edge. A stalled memory lets the bench hold the ring at exactly one byte, which makes the R6 cases visible. Free-running pseudo-random acknowledges across two dozen start addresses of both parities cover straddled words and acknowledges that land in a flush cycle.

// File: rtl/bcp_pkg.sv
package bcp_pkg;

    typedef enum logic [1:0] {
        FMT_SBYTE = 2'd0,
        FMT_UBYTE = 2'd1,
        FMT_WORD  = 2'd2,
        FMT_BIG   = 2'd3
    } op_fmt_e;

    localparam int BEAT_BYTES = 2;

endpackage

// File: rtl/bcp_byte_ring.sv
module bcp_byte_ring #(
    parameter int BUF_BYTES = 4,
    localparam int PTR_W = $clog2(BUF_BYTES),
    localparam int CNT_W = $clog2(BUF_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push_en,
    input  logic             push_hi_only,
    input  logic [15:0]      push_word,
    input  logic [1:0]       pop_n,
    output logic [CNT_W-1:0] cnt,
    output logic [7:0]       peek0,
    output logic [7:0]       peek1
);

    typedef struct packed {
        logic [BUF_BYTES-1:0][7:0] slot;
        logic [PTR_W-1:0]          rd;
        logic [CNT_W-1:0]          cnt;
    } ring_t;

    ring_t s_d, s_q;
    logic [PTR_W-1:0] wr0, wr1, rd1;
    logic [CNT_W-1:0] push_n;

    always_comb begin
        s_d    = s_q;
        wr0    = s_q.rd + s_q.cnt[PTR_W-1:0];
        wr1    = wr0 + PTR_W'(1);
        rd1    = s_q.rd + PTR_W'(1);
        push_n = '0;
        if (push_en) begin
            if (push_hi_only) begin
                s_d.slot[wr0] = push_word[15:8];
                push_n        = CNT_W'(1);
            end else begin
                s_d.slot[wr0] = push_word[7:0];
                s_d.slot[wr1] = push_word[15:8];
                push_n        = CNT_W'(2);
            end
        end
        s_d.rd  = s_q.rd + PTR_W'(pop_n);
        s_d.cnt = s_q.cnt + push_n - CNT_W'(pop_n);
        if (clear) begin
            s_d.rd  = '0;
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt   = s_q.cnt;
    assign peek0 = s_q.slot[s_q.rd];
    assign peek1 = s_q.slot[rd1];

endmodule

// File: rtl/bcp_fetch_ctl.sv
module bcp_fetch_ctl #(
    parameter int ADDR_W    = 16,
    parameter int BUF_BYTES = 4,
    localparam int CNT_W = $clog2(BUF_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [ADDR_W-1:0] flush_addr,
    input  logic              mem_ack,
    input  logic [CNT_W-1:0]  buf_cnt,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              push_en,
    output logic              push_hi_only
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              skip_lo;
    } fetch_t;

    fetch_t s_d, s_q;
    logic   beat;

    always_comb begin
        s_d     = s_q;
        mem_req = buf_cnt <= CNT_W'(BUF_BYTES - bcp_pkg::BEAT_BYTES);
        beat    = mem_req && mem_ack && !flush;
        if (flush) begin
            s_d.addr    = {flush_addr[ADDR_W-1:1], 1'b0};
            s_d.skip_lo = flush_addr[0];
        end else if (beat) begin
            s_d.addr    = s_q.addr + ADDR_W'(bcp_pkg::BEAT_BYTES);
            s_d.skip_lo = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_addr     = s_q.addr;
    assign push_en      = beat;
    assign push_hi_only = s_q.skip_lo;

endmodule

// File: rtl/bcp_op_format.sv
module bcp_op_format #(
    parameter int BUF_BYTES = 4,
    localparam int CNT_W = $clog2(BUF_BYTES + 1)
) (
    input  logic             op_req,
    input  bcp_pkg::op_fmt_e fmt,
    input  logic             flush,
    input  logic [CNT_W-1:0] buf_cnt,
    input  logic [7:0]       peek0,
    input  logic [7:0]       peek1,
    output logic             op_valid,
    output logic [15:0]      op_data,
    output logic [1:0]       pop_n
);

    logic [1:0] need;

    always_comb begin
        need    = 2'd1;
        op_data = {8'h00, peek0};
        unique case (fmt)
            bcp_pkg::FMT_SBYTE: op_data = {{8{peek0[7]}}, peek0};
            bcp_pkg::FMT_UBYTE: op_data = {8'h00, peek0};
            bcp_pkg::FMT_WORD: begin
                need    = 2'd2;
                op_data = {peek1, peek0};
            end
            bcp_pkg::FMT_BIG: begin
                if (peek0[7]) begin
                    need    = 2'd2;
                    op_data = {1'b0, peek0[6:0], peek1};
                end
            end
            default: op_data = {8'h00, peek0};
        endcase
        op_valid = !flush && (buf_cnt >= CNT_W'(need));
        pop_n    = (op_req && op_valid) ? need : 2'd0;
    end

endmodule

// File: rtl/bcp_prefetch.sv
module bcp_prefetch #(
    parameter int ADDR_W    = 16,
    parameter int BUF_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [15:0]       mem_rdata,
    input  logic              flush,
    input  logic [ADDR_W-1:0] flush_addr,
    input  logic              op_req,
    input  logic [1:0]        op_fmt,
    output logic              op_valid,
    output logic [15:0]       op_data
);

    localparam int CNT_W = $clog2(BUF_BYTES + 1);

    logic [CNT_W-1:0] buf_cnt;
    logic [7:0]       peek0, peek1;
    logic [1:0]       pop_n;
    logic             push_en, push_hi_only;

    bcp_fetch_ctl #(.ADDR_W(ADDR_W), .BUF_BYTES(BUF_BYTES)) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush        (flush),
        .flush_addr   (flush_addr),
        .mem_ack      (mem_ack),
        .buf_cnt      (buf_cnt),
        .mem_req      (mem_req),
        .mem_addr     (mem_addr),
        .push_en      (push_en),
        .push_hi_only (push_hi_only)
    );

    bcp_byte_ring #(.BUF_BYTES(BUF_BYTES)) u_ring (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (flush),
        .push_en      (push_en),
        .push_hi_only (push_hi_only),
        .push_word    (mem_rdata),
        .pop_n        (pop_n),
        .cnt          (buf_cnt),
        .peek0        (peek0),
        .peek1        (peek1)
    );

    bcp_op_format #(.BUF_BYTES(BUF_BYTES)) u_fmt (
        .op_req   (op_req),
        .fmt      (bcp_pkg::op_fmt_e'(op_fmt)),
        .flush    (flush),
        .buf_cnt  (buf_cnt),
        .peek0    (peek0),
        .peek1    (peek1),
        .op_valid (op_valid),
        .op_data  (op_data),
        .pop_n    (pop_n)
    );

endmodule

// File: rtl/bcp_prefetch_chk.sv
module bcp_prefetch_chk #(
    parameter int ADDR_W    = 16,
    parameter int BUF_BYTES = 4,
    localparam int CNT_W = $clog2(BUF_BYTES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              flush,
    input logic [1:0]        op_fmt,
    input logic              op_valid,
    input logic [15:0]       op_data,
    input logic [CNT_W-1:0]  buf_cnt
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack && !flush |=> mem_req && $stable(mem_addr)); // R7

    AST_ADDR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !mem_addr[0]); // R7

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack && !flush |=> mem_addr == $past(mem_addr) + ADDR_W'(2)); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        buf_cnt <= CNT_W'(BUF_BYTES)); // R7

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> buf_cnt == '0); // R8

    AST_FLUSH_NO_OP: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !op_valid); // R8

    AST_UBYTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_fmt == 2'd1 |-> op_data[15:8] == 8'h00); // R3

    AST_BIG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_fmt == 2'd3 |-> !op_data[15]); // R5

    AST_EMPTY_NO_OP: assert property (@(posedge clk) disable iff (!rst_n)
        buf_cnt == '0 |-> !op_valid); // R6

endmodule

bind bcp_prefetch bcp_prefetch_chk #(.ADDR_W(ADDR_W), .BUF_BYTES(BUF_BYTES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack),
    .flush    (flush),
    .op_fmt   (op_fmt),
    .op_valid (op_valid),
    .op_data  (op_data),
    .buf_cnt  (buf_cnt)
);

// File: tb/sim_bcp_prefetch.sv
`timescale 1ns/1ps
module sim_bcp_prefetch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        flush = 1'b0;
    logic [15:0] flush_addr = '0;
    logic        op_req = 1'b0;
    logic [1:0]  op_fmt = '0;
    logic        op_valid;
    logic [15:0] op_data;

    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;
    int   exp_ptr = 0;
    int   mem_credit = -1;
    bit   mem_on = 1'b0;
    bit   odd_seen = 1'b0;
    logic [7:0] lfsr = 8'h5a;

    always #2.5 clk = ~clk;

    bcp_prefetch #(.ADDR_W(16), .BUF_BYTES(4)) u0 (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .flush(flush),
        .flush_addr(flush_addr), .op_req(op_req), .op_fmt(op_fmt),
        .op_valid(op_valid), .op_data(op_data)
    );

    function automatic logic [7:0] byte_at(input int a);
        int v;
        v = a * 73 + (a / 8) * 29 + 5;
        return v[7:0];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // memory model: pseudo-random acknowledge, little-endian words
    initial begin
        forever begin
            @(negedge clk);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (mem_req && mem_addr[0]) odd_seen = 1'b1;
            if (mem_req && mem_on && mem_credit != 0 && (lfsr[0] || lfsr[2])) begin
                mem_ack   = 1'b1;
                mem_rdata = {byte_at(int'(mem_addr) + 1), byte_at(int'(mem_addr))};
                if (mem_credit > 0) mem_credit--;
            end else begin
                mem_ack = 1'b0;
            end
        end
    end

    task automatic take(input int fmt, input string extra);
        logic [7:0] b0, b1;
        int expv, n, waitc;
        string tag;
        b0 = byte_at(exp_ptr);
        b1 = byte_at(exp_ptr + 1);
        n = 1;
        case (fmt)
            0: begin expv = {{8{b0[7]}}, b0}; tag = "R2 signed byte"; end
            1: begin expv = {8'h00, b0}; tag = "R3 unsigned byte"; end
            2: begin expv = {b1, b0}; n = 2; tag = "R4 word"; end
            default: begin
                tag = "R5 compact integer";
                if (b0[7]) begin expv = {1'b0, b0[6:0], b1}; n = 2; end
                else expv = {8'h00, b0};
            end
        endcase
        @(negedge clk);
        op_fmt = 2'(fmt);
        op_req = 1'b1;
        waitc = 0;
        #0.5;
        while (!op_valid && waitc < 300) begin
            @(negedge clk);
            #0.5;
            waitc++;
        end
        chk(op_valid && op_data == expv[15:0], {tag, " ", extra}, op_data, expv);
        @(posedge clk);
        #0.5;
        op_req = 1'b0;
        exp_ptr += n;
    endtask

    task automatic do_flush(input int a);
        @(negedge clk);
        flush_addr = a[15:0];
        flush = 1'b1;
        #0.5;
        chk(!op_valid, "R8 operand blocked during flush", op_valid, 0);
        @(posedge clk);
        #0.5;
        flush = 1'b0;
        chk(mem_req && mem_addr == 16'(a & ~1), "R8 refetch address", mem_addr, a & ~1);
        exp_ptr = a;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int a;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        op_req = 1'b1;
        op_fmt = 2'd1;
        #0.5;
        chk(mem_req == 1'b1, "R1 request after reset", mem_req, 1);
        chk(mem_addr == 16'h0, "R1 address after reset", mem_addr, 0);
        chk(!op_valid, "R1 empty after reset", op_valid, 0);
        op_req = 1'b0;
        mem_on = 1'b1;
        exp_ptr = 0;
        for (int k = 0; k < 8; k++) take(k % 4, "R1 stream from 0");

        // idle with data buffered: nothing consumed, refill stops when full
        repeat (20) @(negedge clk);
        #0.5;
        chk(!mem_req, "R7 no refill while ring full", mem_req, 0);
        take(1, "R10 idle keeps bytes");
        take(2, "R10 idle keeps bytes");

        // sweep of start addresses of both parities and format mixes
        for (int s = 0; s < 24; s++) begin
            do_flush(100 + s * 7);
            for (int k = 0; k < 10; k++) begin
                take((k * (s % 3 + 1) + s) % 4, (k == 0 && (s % 2) == 1) ? "R9 odd entry" : "");
                if (k % 4 == 3) repeat (2) @(negedge clk);
            end
        end

        // one byte buffered whose bit 7 is set
        a = 301;
        while (!byte_at(a)[7]) a += 2;
        mem_on = 1'b0;
        do_flush(a);
        mem_credit = 1;
        mem_on = 1'b1;
        repeat (10) @(negedge clk);
        op_fmt = 2'd3;
        op_req = 1'b1;
        #0.5;
        chk(!op_valid, "R6 compact integer waits for second byte", op_valid, 0);
        op_fmt = 2'd2;
        #0.1;
        chk(!op_valid, "R6 word waits for second byte", op_valid, 0);
        op_fmt = 2'd1;
        #0.1;
        chk(op_valid, "R6 single byte ready", op_valid, 1);
        chk(op_data == {8'h00, byte_at(a)}, "R9 odd entry first byte", op_data, byte_at(a));
        op_req = 1'b0;
        mem_credit = -1;
        take(3, "R6 after refill");
        take(0, "R6 after refill");

        chk(!odd_seen, "R7 even request address", odd_seen, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule